// File: doc/BRIEF.md
# Tile-Maximum Coarse Altitude Map Builder

This block turns a fine altitude grid into a coarse obstacle grid. The fine grid sits in a RAM outside the block and has a one-cycle read latency. The coarse grid is written through a separate write port. Each coarse entry holds the highest altitude found in its square tile of fine cells. The coarse map is therefore conservative: a path segment that stays above a coarse entry also stays above every fine cell that the entry covers.

A pulse on the start input, while the block is idle, begins one pass. The block reads the whole fine grid in raster order at one cell per clock. It keeps one running maximum for each tile column of the current tile row. Each coarse entry is written as soon as the last fine cell of its tile has been folded in. A one-cycle done pulse follows the final coarse write. By default the fine grid is 512 by 512 cells of 12 bits and the tiles are 16 by 16 cells, which gives a 32 by 32 coarse grid. Both grid edge and tile edge must be powers of two, and the tile edge must be at least 2.

Top module: `coarse_map_builder`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy_o, done_o, fine_rd_o and coarse_we_o are all low.
- R2: A start_i seen at a clock edge while busy_o is low sets busy_o and begins the pass. In the cycle right after that edge, fine_rd_o is high with fine_addr_o equal to 0. fine_rd_o is never high while busy_o is low.
- R3: During a pass, fine_rd_o stays high for exactly FINE_DIM*FINE_DIM consecutive cycles. In the k-th of those cycles (counting from 0) fine_addr_o equals k, so the address is row*FINE_DIM + column, with the column in the low bits.
- R4: Every coarse entry written equals the largest fine altitude, compared as an unsigned number, in the tile that covers fine rows TILE*i to TILE*i+TILE-1 and fine columns TILE*j to TILE*j+TILE-1.
- R5: The entry for tile (i, j) is written at coarse_addr_o = i*COARSE_DIM + j. Each entry is written exactly once per pass, in ascending address order, and coarse_we_o is never high in two consecutive cycles.
- R6: The write for a tile appears two cycles after the cycle in which the read address of that tile's bottom-right fine cell was issued.
- R7: done_o is high for exactly one cycle, the cycle right after the last coarse write. busy_o falls in that same cycle.
- R8: start_i has no effect while busy_o is high. The read sequence of the pass goes on unchanged.
- R9: The running maxima are restarted at the first cell of every tile, so no value from an earlier tile row or from an earlier pass reaches a later coarse entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a pass (taken only while idle) |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse after the final coarse write |
| fine_rd_o | output | 1 | Read enable to the fine-map RAM |
| fine_addr_o | output | 2*log2(FINE_DIM) | Fine-map read address, row in the high bits |
| fine_data_i | input | ALT_W | Fine altitude, valid one cycle after the read |
| coarse_we_o | output | 1 | Write enable to the coarse map |
| coarse_addr_o | output | 2*log2(FINE_DIM/TILE) | Coarse-map write address, tile row in the high bits |
| coarse_data_o | output | ALT_W | Tile maximum to be written |

## Verification
A start accepted at edge E0 puts the k-th read on the port in the cycle after edge Ek. The altitude for that read comes back one edge later. A tile's maximum appears at the coarse port one edge after that, so the write for fine cell m falls in cycle m+2. done_o is due in cycle N+2, where N is the fine-cell count, and busy_o falls in that cycle as well. The bench counts edges from the accepted start and predicts every output for every cycle from that count and from tile maxima it computes straight from its own RAM image. It samples on the falling edge and drives start_i only there, so each comparison hits exactly the cycle the timing above names.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  // unsigned maximum on a 32-bit container; callers truncate to their width
  function automatic logic [31:0] umax32(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? a : b;
  endfunction

endpackage

// File: rtl/cmap_scan.sv
module cmap_scan
  import cmap_pkg::*;
#(
  parameter int FINE_DIM   = 512,
  parameter int COARSE_DIM = 32,
  localparam int FA_W      = 2 * $clog2(FINE_DIM),
  localparam int CA_W      = 2 * $clog2(COARSE_DIM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            wr_seen_i,
  input  logic [CA_W-1:0] wr_addr_i,
  output logic            busy_o,
  output logic            rd_o,
  output logic [FA_W-1:0] addr_o,
  output logic            done_o
);

  localparam logic [FA_W-1:0] F_LAST = '1;
  localparam logic [CA_W-1:0] C_LAST = '1;
  localparam logic [FA_W-1:0] F_ONE  = FA_W'(1);

  phase_t          phase_q;
  logic [FA_W-1:0] addr_q;
  logic            done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_READ;
            addr_q  <= '0;
          end
        end
        PH_READ: begin
          if (addr_q == F_LAST) phase_q <= PH_DRAIN;
          else                  addr_q  <= addr_q + F_ONE;
        end
        PH_DRAIN: begin
          if (wr_seen_i && wr_addr_i == C_LAST) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign rd_o   = (phase_q == PH_READ);
  assign addr_o = addr_q;
  assign done_o = done_q;

  // raster order, one address per clock
  assert_raster_step_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_o && addr_o != F_LAST) |=> (rd_o && addr_o == $past(addr_o) + F_ONE));

  // a pass can only begin from idle
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !(rd_o && addr_o == '0));

  assert_no_read_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !rd_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_follows_write_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(wr_seen_i) && !busy_o));

endmodule

// File: rtl/cmap_tilemax.sv
module cmap_tilemax
  import cmap_pkg::*;
#(
  parameter int FINE_DIM   = 512,
  parameter int TILE       = 16,
  parameter int ALT_W      = 12,
  localparam int FC_W      = $clog2(FINE_DIM),
  localparam int TB        = $clog2(TILE),
  localparam int CC_W      = FC_W - TB,
  localparam int COARSE_DIM = FINE_DIM / TILE,
  localparam int FA_W      = 2 * FC_W,
  localparam int CA_W      = 2 * CC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_i,
  input  logic [FA_W-1:0]  addr_i,
  input  logic [ALT_W-1:0] data_i,
  output logic             we_o,
  output logic [CA_W-1:0]  waddr_o,
  output logic [ALT_W-1:0] wdata_o
);

  // tags travel one stage alongside the RAM read latency
  logic            v1_q;
  logic [FA_W-1:0] a1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      a1_q <= '0;
    end else begin
      v1_q <= rd_i;
      a1_q <= addr_i;
    end
  end

  logic [FC_W-1:0] row1, col1;
  logic [CC_W-1:0] trow, tcol;
  logic            tile_first, tile_last;
  logic [ALT_W-1:0] cur_max, merged;
  logic [31:0]     wide_max;
  logic [ALT_W-1:0] bank_q [COARSE_DIM];

  assign row1       = a1_q[FA_W-1:FC_W];
  assign col1       = a1_q[FC_W-1:0];
  assign trow       = row1[FC_W-1:TB];
  assign tcol       = col1[FC_W-1:TB];
  assign tile_first = (row1[TB-1:0] == '0) && (col1[TB-1:0] == '0);
  assign tile_last  = (&row1[TB-1:0]) && (&col1[TB-1:0]);
  assign cur_max    = bank_q[tcol];
  assign wide_max   = umax32(32'(cur_max), 32'(data_i));
  assign merged     = tile_first ? data_i : wide_max[ALT_W-1:0];

  // one running maximum per tile column
  for (genvar g = 0; g < COARSE_DIM; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (v1_q && tcol == CC_W'(g)) bank_q[g] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= v1_q && tile_last;
      if (v1_q && tile_last) begin
        waddr_o <= {trow, tcol};
        wdata_o <= merged;
      end
    end
  end

  // a written maximum never falls below the cell that closed its tile
  assert_conservative_R4: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (wdata_o >= $past(data_i)));

  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    we_o |-> $past(v1_q));

  if (TILE > 1) begin : g_spacing
    assert_single_write_R5: assert property (@(posedge clk) disable iff (rst)
      we_o |=> !we_o);
  end

endmodule

// File: rtl/coarse_map_builder.sv
module coarse_map_builder #(
  parameter int FINE_DIM    = 512,
  parameter int TILE        = 16,
  parameter int ALT_W       = 12,
  localparam int COARSE_DIM = FINE_DIM / TILE,
  localparam int FA_W       = 2 * $clog2(FINE_DIM),
  localparam int CA_W       = 2 * $clog2(COARSE_DIM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fine_rd_o,
  output logic [FA_W-1:0]  fine_addr_o,
  input  logic [ALT_W-1:0] fine_data_i,
  output logic             coarse_we_o,
  output logic [CA_W-1:0]  coarse_addr_o,
  output logic [ALT_W-1:0] coarse_data_o
);

  cmap_scan #(
    .FINE_DIM  (FINE_DIM),
    .COARSE_DIM(COARSE_DIM)
  ) u_scan (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .wr_seen_i(coarse_we_o),
    .wr_addr_i(coarse_addr_o),
    .busy_o   (busy_o),
    .rd_o     (fine_rd_o),
    .addr_o   (fine_addr_o),
    .done_o   (done_o)
  );

  cmap_tilemax #(
    .FINE_DIM(FINE_DIM),
    .TILE    (TILE),
    .ALT_W   (ALT_W)
  ) u_tilemax (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (fine_rd_o),
    .addr_i (fine_addr_o),
    .data_i (fine_data_i),
    .we_o   (coarse_we_o),
    .waddr_o(coarse_addr_o),
    .wdata_o(coarse_data_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !done_o && !fine_rd_o && !coarse_we_o));

endmodule

// File: tb/tb_coarse_map_builder.sv
module tb_coarse_map_builder;

  localparam int FD = 64;
  localparam int TL = 16;
  localparam int CD = FD / TL;
  localparam int N  = FD * FD;
  localparam int W  = 12;
  localparam int FA_W = 2 * $clog2(FD);
  localparam int CA_W = 2 * $clog2(CD);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic            busy_o, done_o, fine_rd_o, coarse_we_o;
  logic [FA_W-1:0] fine_addr_o;
  logic [W-1:0]    fine_data_i = '0;
  logic [CA_W-1:0] coarse_addr_o;
  logic [W-1:0]    coarse_data_o;

  always #4 clk = ~clk;

  coarse_map_builder #(.FINE_DIM(FD), .TILE(TL), .ALT_W(W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o),
    .fine_rd_o(fine_rd_o), .fine_addr_o(fine_addr_o), .fine_data_i(fine_data_i),
    .coarse_we_o(coarse_we_o), .coarse_addr_o(coarse_addr_o), .coarse_data_o(coarse_data_o)
  );

  logic [W-1:0] mem [N];
  int           tmax [CD*CD];
  int           checks = 0;
  int           errors = 0;
  bit           finished = 1'b0;
  int           lcg = 12345;

  // fine RAM, one-cycle read latency
  always @(posedge clk) if (fine_rd_o) fine_data_i <= mem[fine_addr_o];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic fill(input int mode);
    for (int r = 0; r < FD; r++)
      for (int c = 0; c < FD; c++) begin
        int v;
        case (mode)
          0: v = 0;
          1: begin lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; v = (lcg >> 8) & 12'hfff; end
          2: v = (r < TL) ? 4095 : ((r * 7 + c) % 50);
          default: v = 4095;
        endcase
        mem[r*FD+c] = W'(v);
      end
    if (mode == 0)
      for (int tr = 0; tr < CD; tr++)
        for (int tc = 0; tc < CD; tc++) begin
          int pr = tr*TL + ((tr + tc*3) % TL);
          int pc = tc*TL + ((tr*5 + tc) % TL);
          mem[pr*FD+pc] = W'(100 + tr*4 + tc);
        end
    if (mode == 0) begin
      mem[N-1] = W'(777);  // bottom-right corner of last tile
    end
    for (int t = 0; t < CD*CD; t++) tmax[t] = 0;
    for (int r = 0; r < FD; r++)
      for (int c = 0; c < FD; c++) begin
        int t = (r/TL)*CD + c/TL;
        if (int'(mem[r*FD+c]) > tmax[t]) tmax[t] = int'(mem[r*FD+c]);
      end
  endtask

  // one pass; start accepted at edge E0, interval k follows edge Ek
  task automatic run_pass(input bit burst);
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= N + 4; k++) begin
      int m;
      bit exp_we, exp_rd, exp_busy, exp_done;
      @(negedge clk);
      start_i = burst && (k == 100 || k == N/2 || k == N + 1);
      exp_rd   = (k < N);
      exp_busy = (k <= N + 1);
      exp_done = (k == N + 2);
      m = k - 2;
      exp_we = (m >= 0 && m < N && ((m / FD) % TL == TL-1) && ((m % FD) % TL == TL-1));
      chk(fine_rd_o == exp_rd, "R3 rd", int'(fine_rd_o), int'(exp_rd));
      if (exp_rd) chk(int'(fine_addr_o) == k, k == 0 ? "R2 first addr" : (burst ? "R8 addr" : "R3 addr"),
                      int'(fine_addr_o), k);
      chk(busy_o == exp_busy, "R7 busy", int'(busy_o), int'(exp_busy));
      chk(done_o == exp_done, "R7 done", int'(done_o), int'(exp_done));
      chk(coarse_we_o == exp_we, "R6 we", int'(coarse_we_o), int'(exp_we));
      if (exp_we && coarse_we_o) begin
        int t = ((m / FD) / TL) * CD + (m % FD) / TL;
        chk(int'(coarse_addr_o) == t, "R5 addr", int'(coarse_addr_o), t);
        chk(int'(coarse_data_o) == tmax[t], "R4 R9 data", int'(coarse_data_o), tmax[t]);
      end
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o && !fine_rd_o && !coarse_we_o, "R1 in reset", 1, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !fine_rd_o && !coarse_we_o, "R1 after reset", 1, 0);

    fill(0); run_pass(1'b0);   // isolated peaks, corners included
    fill(1); run_pass(1'b1);   // random data, start pulses while busy (R8)
    fill(2); run_pass(1'b0);   // high top tile row then low rows (R9)
    fill(3); run_pass(1'b0);   // full scale
    fill(0); run_pass(1'b0);   // small peaks after full-scale pass (R9)

    repeat (5) begin
      @(negedge clk);
      chk(!busy_o && !fine_rd_o && !coarse_we_o && !done_o, "R2 idle", 0, 0);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule